// File: doc/BRIEF.md
# Multi-bank even clock divider

This block derives four square-wave levels from one fast master clock: three configurable banks (A, B, C) and one feedback level. Each bank and the feedback output divide a common source rate by an even ratio, so every output has a 50% duty cycle. The source is either the master clock itself or, in bypass mode, the rising edges of a slower reference clock. The reference is resynchronised into the master domain. An optional prescale stage halves the source rate before it reaches the dividers.

All configuration (bank codes, feedback code, bypass and halve) is captured only while the block is held in master reset. When master reset drops, every divider starts on the same source event, so all outputs rise together. A code change made while running is ignored until the next master reset, which keeps pulse widths intact.

Top module: `clkdiv_bank_top`

## Requirements
- R1: A bank code (4 bits, per bank) of 0, 1, 2 or 3 divides the source by 2, 4, 6 or 8. The bank output period is that many source ticks.
- R2: A feedback code (3 bits) of 0 to 5 divides the source by 4, 6, 8, 16, 24 and 32, in that order.
- R3: Bank codes 4 to 15 and feedback codes 6 and 7 divide by 2.
- R4: Each output stays high for half its period and low for the other half, measured in source ticks.
- R5: With halve set, the source tick rate is half the undivided rate, so every period doubles.
- R6: With bypass set, one source tick occurs per rising edge of the reference clock, and the master clock only samples that edge. The reference must run below half the master rate.
- R7: Master reset (active high, synchronous) drives every output low within two master cycles and holds them low while it stays high.
- R8: In master-clock mode, when master reset is sampled low at one master edge, all four outputs go high together after the following edge.
- R9: A change of any code, of bypass or of halve while running does not alter the outputs until the next master reset. At that reset the new values are captured.
- R10: The active-low reset forces all outputs low at once, without a clock edge, and is released synchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mst | input | 1 | Fast master clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ref | input | 1 | Reference clock used as source in bypass mode |
| bypass_i | input | 1 | 1: source ticks come from reference rising edges |
| halve_i | input | 1 | 1: source rate divided by two before the dividers |
| mreset_i | input | 1 | Master reset, active high; captures configuration |
| sel_bank_i | input | BANKS*4 | Bank codes; bits [3:0] bank A, [7:4] bank B, [11:8] bank C |
| sel_fb_i | input | 3 | Feedback divide code |
| out_bank_o | output | BANKS | Bank levels; bit 0 is A, bit 1 is B, bit 2 is C |
| out_fb_o | output | 1 | Feedback level |

## Verification
Several properties are checked on every cycle. Outputs are low whenever the block is held, and low two cycles after master reset. The captured configuration cannot move while running. No output changes in a cycle without a source tick. Halved ticks are never adjacent. In master-clock mode all outputs rise on the first cycle after release. The actual ratio for each code, the high and low widths, the bypass timing, the deferred effect of a mid-run code change and the asynchronous reset need measured periods, so only the bench's scenarios show them.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int BANK_SEL_W = 4;
  localparam int FB_SEL_W   = 3;
  localparam int MAX_DIV    = 32;
  localparam int DIV_CNT_W  = $clog2(MAX_DIV / 2);

  // even ratio selected by a bank code; unassigned codes fall back to 2
  function automatic int bank_ratio(logic [BANK_SEL_W-1:0] code);
    case (code)
      4'd1:    return 4;
      4'd2:    return 6;
      4'd3:    return 8;
      default: return 2;
    endcase
  endfunction

  // even ratio selected by the feedback code; unassigned codes fall back to 2
  function automatic int fb_ratio(logic [FB_SEL_W-1:0] code);
    case (code)
      3'd0:    return 4;
      3'd1:    return 6;
      3'd2:    return 8;
      3'd3:    return 16;
      3'd4:    return 24;
      3'd5:    return 32;
      default: return 2;
    endcase
  endfunction

  // terminal count of the half-period counter for a given even ratio
  function automatic logic [DIV_CNT_W-1:0] half_term(int ratio);
    return DIV_CNT_W'(ratio / 2 - 1);
  endfunction

endpackage

// File: rtl/clkdiv_cfg.sv
module clkdiv_cfg
  import clkdiv_pkg::*;
#(
  parameter int BANKS = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic                          bypass_i,
  input  logic                          halve_i,
  input  logic [BANKS*BANK_SEL_W-1:0]   sel_bank_i,
  input  logic [FB_SEL_W-1:0]           sel_fb_i,
  output logic [BANKS*DIV_CNT_W-1:0]    term_bank_o,
  output logic [DIV_CNT_W-1:0]          term_fb_o,
  output logic                          bypass_o,
  output logic                          halve_o
);

  logic [BANKS*DIV_CNT_W-1:0] term_bank_dec, term_bank_d, term_bank_q;
  logic [DIV_CNT_W-1:0]       term_fb_d, term_fb_q;
  logic                       bypass_d, bypass_q, halve_d, halve_q;

  for (genvar g = 0; g < BANKS; g++) begin : g_dec
    assign term_bank_dec[g*DIV_CNT_W +: DIV_CNT_W] =
      half_term(bank_ratio(sel_bank_i[g*BANK_SEL_W +: BANK_SEL_W]));
  end

  always_comb begin
    term_bank_d = term_bank_q;
    term_fb_d   = term_fb_q;
    bypass_d    = bypass_q;
    halve_d     = halve_q;
    if (load) begin
      term_bank_d = term_bank_dec;
      term_fb_d   = half_term(fb_ratio(sel_fb_i));
      bypass_d    = bypass_i;
      halve_d     = halve_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_bank_q <= '0;
      term_fb_q   <= '0;
      bypass_q    <= 1'b0;
      halve_q     <= 1'b0;
    end else begin
      term_bank_q <= term_bank_d;
      term_fb_q   <= term_fb_d;
      bypass_q    <= bypass_d;
      halve_q     <= halve_d;
    end
  end

  assign term_bank_o = term_bank_q;
  assign term_fb_o   = term_fb_q;
  assign bypass_o    = bypass_q;
  assign halve_o     = halve_q;

endmodule

// File: rtl/clkdiv_src.sv
module clkdiv_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic bypass,
  input  logic halve,
  input  logic clk_ref,
  output logic tick_o
);

  logic [SYNC_STAGES:0] ref_sh_q, ref_sh_d;
  logic                 ref_rise, raw_evt;
  logic                 phase_q, phase_d;

  always_comb begin
    ref_sh_d = {ref_sh_q[SYNC_STAGES-1:0], clk_ref};
  end

  assign ref_rise = ref_sh_q[SYNC_STAGES-1] & ~ref_sh_q[SYNC_STAGES];
  assign raw_evt  = bypass ? ref_rise : 1'b1;

  always_comb begin
    phase_d = phase_q;
    if (!run)         phase_d = 1'b0;
    else if (raw_evt) phase_d = ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_sh_q <= '0;
      phase_q  <= 1'b0;
    end else begin
      ref_sh_q <= ref_sh_d;
      phase_q  <= phase_d;
    end
  end

  // the first event after release always passes, so the halved stream starts at once
  assign tick_o = run & raw_evt & (~halve | ~phase_q);

endmodule

// File: rtl/clkdiv_even.sv
module clkdiv_even #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] term,
  output logic             level_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;
  logic             live_q, live_d;

  always_comb begin
    cnt_d  = cnt_q;
    lvl_d  = lvl_q;
    live_d = live_q;
    if (clr) begin
      cnt_d  = '0;
      lvl_d  = 1'b0;
      live_d = 1'b0;
    end else if (tick) begin
      if (!live_q) begin
        live_d = 1'b1;
        lvl_d  = 1'b1;
        cnt_d  = '0;
      end else if (cnt_q == term) begin
        cnt_d = '0;
        lvl_d = ~lvl_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lvl_q  <= 1'b0;
      live_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lvl_q  <= lvl_d;
      live_q <= live_d;
    end
  end

  assign level_o = lvl_q;

endmodule

// File: rtl/clkdiv_bank_top.sv
module clkdiv_bank_top
  import clkdiv_pkg::*;
#(
  parameter int BANKS       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk_mst,
  input  logic                        rst_n,
  input  logic                        clk_ref,
  input  logic                        bypass_i,
  input  logic                        halve_i,
  input  logic                        mreset_i,
  input  logic [BANKS*BANK_SEL_W-1:0] sel_bank_i,
  input  logic [FB_SEL_W-1:0]         sel_fb_i,
  output logic [BANKS-1:0]            out_bank_o,
  output logic                        out_fb_o
);

  localparam int CFG_W = (BANKS + 1) * DIV_CNT_W + 2;

  logic [1:0]                 rst_sync_q;
  logic                       rst_core_n;
  logic                       run_q, run_d;
  logic                       tick;
  logic [BANKS*DIV_CNT_W-1:0] term_bank;
  logic [DIV_CNT_W-1:0]       term_fb;
  logic                       byp_q, halve_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_mst or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  always_comb run_d = ~mreset_i;

  always_ff @(posedge clk_mst or negedge rst_core_n) begin
    if (!rst_core_n) run_q <= 1'b0;
    else             run_q <= run_d;
  end

  clkdiv_cfg #(.BANKS(BANKS)) u_cfg (
    .clk        (clk_mst),
    .rst_n      (rst_core_n),
    .load       (~run_q),
    .bypass_i   (bypass_i),
    .halve_i    (halve_i),
    .sel_bank_i (sel_bank_i),
    .sel_fb_i   (sel_fb_i),
    .term_bank_o(term_bank),
    .term_fb_o  (term_fb),
    .bypass_o   (byp_q),
    .halve_o    (halve_q)
  );

  clkdiv_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk    (clk_mst),
    .rst_n  (rst_core_n),
    .run    (run_q),
    .bypass (byp_q),
    .halve  (halve_q),
    .clk_ref(clk_ref),
    .tick_o (tick)
  );

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    clkdiv_even #(.CNT_W(DIV_CNT_W)) u_div (
      .clk    (clk_mst),
      .rst_n  (rst_core_n),
      .clr    (~run_q),
      .tick   (tick),
      .term   (term_bank[g*DIV_CNT_W +: DIV_CNT_W]),
      .level_o(out_bank_o[g])
    );
  end

  clkdiv_even #(.CNT_W(DIV_CNT_W)) u_fb (
    .clk    (clk_mst),
    .rst_n  (rst_core_n),
    .clr    (~run_q),
    .tick   (tick),
    .term   (term_fb),
    .level_o(out_fb_o)
  );

endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk #(
  parameter int BANKS = 3,
  parameter int CFG_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mreset_i,
  input logic             run_q,
  input logic             tick,
  input logic             halve_q,
  input logic             byp_q,
  input logic [CFG_W-1:0] cfg_q,
  input logic [BANKS-1:0] out_bank,
  input logic             out_fb
);

  // R7: held dividers keep every output low
  p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (out_bank == '0 && !out_fb));

  // R7: master reset reaches the outputs within two cycles
  p_mreset_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mreset_i |-> ##2 (out_bank == '0 && !out_fb));

  // R9: captured configuration cannot move while running
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(cfg_q));

  // R5: halved ticks are never back to back
  p_halve_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (halve_q && tick) |=> !tick);

  // R4: outputs only move on a source tick
  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick) |=> ($stable(out_bank) && $stable(out_fb)));

  // R8: in master-clock mode all outputs rise together right after release
  p_first_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(run_q) && !byp_q) |=> (out_bank == '1 && out_fb));

endmodule

bind clkdiv_bank_top clkdiv_bank_chk #(.BANKS(BANKS), .CFG_W(CFG_W)) u_chk (
  .clk     (clk_mst),
  .rst_n   (rst_n),
  .mreset_i(mreset_i),
  .run_q   (run_q),
  .tick    (tick),
  .halve_q (halve_q),
  .byp_q   (byp_q),
  .cfg_q   ({term_bank, term_fb, byp_q, halve_q}),
  .out_bank(out_bank_o),
  .out_fb  (out_fb_o)
);

// File: tb/clkdiv_bank_top_test.sv
module clkdiv_bank_top_test;

  localparam int CLK_T   = 10;
  localparam int REF_CYC = 4;   // reference period in master cycles
  localparam int NVEC    = 12;

  typedef struct packed {
    logic       byp;
    logic       hlv;
    logic       dflt;
    logic [3:0] sa, sb, sc;
    logic [2:0] sf;
    int         da, db, dc, df;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 1'b0, 4'd0,  4'd1,  4'd2, 3'd0, 2, 4, 6, 4},
    '{1'b0, 1'b0, 1'b0, 4'd3,  4'd0,  4'd1, 3'd1, 8, 2, 4, 6},
    '{1'b0, 1'b1, 1'b0, 4'd1,  4'd2,  4'd3, 3'd2, 4, 6, 8, 8},
    '{1'b0, 1'b0, 1'b0, 4'd2,  4'd3,  4'd0, 3'd3, 6, 8, 2, 16},
    '{1'b0, 1'b1, 1'b0, 4'd0,  4'd1,  4'd2, 3'd4, 2, 4, 6, 24},
    '{1'b0, 1'b0, 1'b0, 4'd1,  4'd2,  4'd3, 3'd5, 4, 6, 8, 32},
    '{1'b0, 1'b1, 1'b0, 4'd3,  4'd0,  4'd1, 3'd5, 8, 2, 4, 32},
    '{1'b0, 1'b0, 1'b1, 4'd9,  4'd15, 4'd4, 3'd6, 2, 2, 2, 2},
    '{1'b1, 1'b0, 1'b0, 4'd1,  4'd0,  4'd3, 3'd0, 4, 2, 8, 4},
    '{1'b1, 1'b1, 1'b1, 4'd2,  4'd3,  4'd1, 3'd7, 6, 8, 4, 2},
    '{1'b0, 1'b1, 1'b0, 4'd2,  4'd3,  4'd0, 3'd3, 6, 8, 2, 16},
    '{1'b0, 1'b1, 1'b1, 4'd15, 4'd1,  4'd2, 3'd0, 2, 4, 6, 4}
  };

  logic       clk_mst, rst_n, clk_ref, bypass_i, halve_i, mreset_i;
  logic [11:0] sel_bank_i;
  logic [2:0] sel_fb_i;
  logic [2:0] out_bank_o;
  logic       out_fb_o;

  int total = 0;
  int bad   = 0;

  clkdiv_bank_top uut (
    .clk_mst   (clk_mst),
    .rst_n     (rst_n),
    .clk_ref   (clk_ref),
    .bypass_i  (bypass_i),
    .halve_i   (halve_i),
    .mreset_i  (mreset_i),
    .sel_bank_i(sel_bank_i),
    .sel_fb_i  (sel_fb_i),
    .out_bank_o(out_bank_o),
    .out_fb_o  (out_fb_o)
  );

  initial begin
    clk_mst = 1'b0;
    forever #(CLK_T/2) clk_mst = ~clk_mst;
  end

  initial begin
    clk_ref = 1'b0;
    #3;
    forever #(REF_CYC*CLK_T/2) clk_ref = ~clk_ref;
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic pick(int idx);
    return (idx < 3) ? out_bank_o[idx] : out_fb_o;
  endfunction

  // periods and high widths counted in master cycles, sampled at falling edges
  task automatic measure(int idx, output int per, output int hi);
    logic prev, cur;
    int guard;
    per = -1; hi = -1;
    prev = pick(idx);
    guard = 0;
    forever begin
      @(negedge clk_mst);
      cur = pick(idx);
      guard++;
      if (!prev && cur) break;
      prev = cur;
      if (guard > 4000) return;
    end
    hi = 1;
    forever begin
      @(negedge clk_mst);
      if (!pick(idx)) break;
      hi++;
      if (hi > 4000) return;
    end
    per = hi + 1;
    forever begin
      @(negedge clk_mst);
      if (pick(idx)) break;
      per++;
      if (per > 4000) begin per = -1; return; end
    end
  endtask

  task automatic load_cfg(vec_t v);
    @(negedge clk_mst);
    mreset_i   = 1'b1;
    bypass_i   = v.byp;
    halve_i    = v.hlv;
    sel_bank_i = {v.sc, v.sb, v.sa};
    sel_fb_i   = v.sf;
    repeat (3) @(negedge clk_mst);
    mreset_i = 1'b0;
  endtask

  function automatic string ptag(vec_t v, int idx);
    if (v.dflt) return "R3";
    if (v.byp)  return "R6";
    if (v.hlv)  return "R5";
    return (idx == 3) ? "R2" : "R1";
  endfunction

  initial begin
    #(CLK_T * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int per, hi, scale, exp;
    vec_t v;
    rst_n = 1'b0; mreset_i = 1'b1; bypass_i = 1'b0; halve_i = 1'b0;
    sel_bank_i = '0; sel_fb_i = '0;
    repeat (3) @(negedge clk_mst);
    // R10: outputs low under reset
    chk("R10 reset state", {29'd0, out_bank_o} + int'(out_fb_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk_mst);
    // R7: still low while master reset held
    chk("R7 held low", {29'd0, out_bank_o} + int'(out_fb_o), 0);

    for (int i = 0; i < NVEC; i++) begin
      v = VECS[i];
      load_cfg(v);
      scale = (v.hlv ? 2 : 1) * (v.byp ? REF_CYC : 1);
      for (int k = 0; k < 4; k++) begin
        exp = (k == 0) ? v.da : (k == 1) ? v.db : (k == 2) ? v.dc : v.df;
        measure(k, per, hi);
        chk($sformatf("%s period row%0d out%0d", ptag(v, k), i, k), per, exp * scale);
        chk($sformatf("R4 high row%0d out%0d", i, k), hi, exp * scale / 2);
      end
    end

    // R8: simultaneous first rise, master mode, both halve settings
    for (int h = 0; h < 2; h++) begin
      v = VECS[0];
      v.hlv = h[0];
      @(negedge clk_mst);
      mreset_i = 1'b1; halve_i = v.hlv; bypass_i = 1'b0;
      sel_bank_i = {v.sc, v.sb, v.sa}; sel_fb_i = v.sf;
      repeat (3) @(negedge clk_mst);
      mreset_i = 1'b0;
      @(negedge clk_mst);
      chk("R8 low before start", {28'd0, out_bank_o, out_fb_o}, 0);
      @(negedge clk_mst);
      chk("R8 all rise together", {28'd0, out_bank_o, out_fb_o}, 15);
    end

    // R7: master reset mid-run forces outputs low in two cycles and keeps them low
    repeat (5) @(negedge clk_mst);
    mreset_i = 1'b1;
    @(posedge clk_mst); @(posedge clk_mst); @(negedge clk_mst);
    hi = 0;
    for (int c = 0; c < 10; c++) begin
      if (out_bank_o != 3'b000 || out_fb_o) hi++;
      @(negedge clk_mst);
    end
    chk("R7 low during master reset", hi, 0);

    // R9: mid-run changes ignored, then taken at the next master reset
    bypass_i = 1'b0; halve_i = 1'b0; sel_bank_i = 12'h001; sel_fb_i = 3'd0;
    repeat (2) @(negedge clk_mst);
    mreset_i = 1'b0;
    repeat (6) @(negedge clk_mst);
    sel_bank_i = 12'h003; halve_i = 1'b1; bypass_i = 1'b1; sel_fb_i = 3'd5;
    measure(0, per, hi);
    chk("R9 bank A unchanged mid-run", per, 4);
    measure(3, per, hi);
    chk("R9 feedback unchanged mid-run", per, 4);
    @(negedge clk_mst);
    mreset_i = 1'b1;
    repeat (3) @(negedge clk_mst);
    mreset_i = 1'b0;
    measure(0, per, hi);
    chk("R9 bank A new ratio after reset", per, 8 * 2 * REF_CYC);

    // R10: asynchronous reset takes effect between clock edges
    @(negedge clk_mst);
    bypass_i = 1'b0; halve_i = 1'b0; sel_bank_i = 12'h000; sel_fb_i = 3'd7;
    mreset_i = 1'b1;
    repeat (3) @(negedge clk_mst);
    mreset_i = 1'b0;
    @(negedge clk_mst);
    @(negedge clk_mst);   // all outputs high here after the first tick
    #1;
    rst_n = 1'b0;
    #1;
    chk("R10 async clear", {28'd0, out_bank_o, out_fb_o}, 0);
    @(negedge clk_mst);
    rst_n = 1'b1;
    repeat (3) @(negedge clk_mst);
    measure(1, per, hi);
    chk("R10 restart after reset", per, 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule